// File: doc/BRIEF.md
# Interrupt Vector File with Group Select

This block keeps one interrupt entry per message bus attached to a core. Each entry stores a handler address, an enable flag, a select flag and a pending flag. Software drives a single command port carrying an opcode, an entry index and a data word. Through this port it can enable, disable or set one entry by index. It can also write an entry's select flag or its handler address. Three group opcodes apply enable, disable or set, in one cycle, to every entry whose select flag is 1. This makes it cheap to arm or trigger several buses at once.

A bus event input or a set command makes an entry pending. An entry takes part in arbitration only while it is both pending and enabled. The lowest such index wins, and its handler address is driven on the vector output. The request output is additionally gated by the core's global interrupt-enable status bit. An acknowledge pulse clears the pending flag of the entry that is currently winning.

Top module: `irq_vector_file`

## Requirements
- R1: Synchronous active-low reset clears every enable, select and pending flag and every handler address to 0. After reset, irq_o is 0 and vec_o is 0.
- R2: Opcode 1 sets the enable flag of entry cmd_idx. Opcode 2 clears it. No other entry changes.
- R3: Opcode 3 makes entry cmd_idx pending.
- R4: A 1 on evt_i[k] at a clock edge makes entry k pending.
- R5: Group opcodes 4 (enable), 5 (disable) and 6 (set pending) act, in the same cycle, on exactly the entries whose select flag is 1. Unselected entries are left as they were.
- R6: Opcode 7 writes cmd_data[0] into the select flag of entry cmd_idx. Opcode 8 writes all of cmd_data into the handler address of entry cmd_idx.
- R7: irq_o is 1 exactly when gie_i is 1 and at least one entry is both pending and enabled. A pending entry that is disabled keeps its pending flag and raises a request once it is enabled.
- R8: vec_o carries the handler address of the lowest-indexed entry that is pending and enabled, whatever the value of gie_i. vec_o is 0 when no entry qualifies.
- R9: ack_i at a clock edge where irq_o is 1 clears the pending flag of the winning entry only. ack_i while irq_o is 0 has no effect.
- R10: If an event or set command targets the winning entry in the same cycle as an acknowledge, that entry stays pending.
- R11: Opcode 0 and opcodes 9 to 15 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_op | input | 4 | Command opcode, 0 = no command |
| cmd_idx | input | IDX_W | Entry index for the single-entry opcodes |
| cmd_data | input | ADDR_W | Handler address, or select value in bit 0 |
| evt_i | input | NUM_SRC | Per-bus event inputs |
| gie_i | input | 1 | Global interrupt-enable status bit |
| ack_i | input | 1 | Acknowledge of the current winner |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | ADDR_W | Handler address of the winning entry |

## Verification
The assertions assume that cmd_idx always names an existing entry and that at most one command arrives per cycle. The stimulus keeps every index below NUM_SRC. The acknowledge property is checked only in cycles with no competing event or set opcode, because those cycles fall under R10. The bench applies those competing cycles on purpose, at the ports, to cover that case. Group commands are issued only after select flags have been written explicitly, so the set of affected entries is known in every case.

// File: rtl/ivf_pkg.sv
// Package: shared opcodes and the per-entry command strobe bundle.
// Assumes a 4-bit opcode field. Codes not listed here are treated as no-ops.
package ivf_pkg;
    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_EN_ONE  = 4'd1,
        OP_DIS_ONE = 4'd2,
        OP_SET_ONE = 4'd3,
        OP_EN_GRP  = 4'd4,
        OP_DIS_GRP = 4'd5,
        OP_SET_GRP = 4'd6,
        OP_SEL_WR  = 4'd7,
        OP_ADR_WR  = 4'd8
    } ivf_op_e;

    typedef struct packed {
        logic en;
        logic dis;
        logic set;
        logic sel_wr;
        logic adr_wr;
    } ivf_strobe_t;
endpackage

// File: rtl/ivf_cmd_dec.sv
// Module: ivf_cmd_dec
// Turns one command into a strobe bundle for each entry. Single-entry opcodes
// match on the index. Group opcodes match on each entry's current select flag.
// Assumes at most one command per cycle.
module ivf_cmd_dec
    import ivf_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int IDX_W   = 2
) (
    input  logic [3:0]         cmd_op,
    input  logic [IDX_W-1:0]   cmd_idx,
    input  logic [NUM_SRC-1:0] sel_q,
    output ivf_strobe_t        strb [NUM_SRC]
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_dec
        logic hit;
        // Compare the index against this entry's position.
        always_comb hit = (32'(cmd_idx) == g);

        // Build this entry's strobes from the opcode and its own match terms.
        always_comb begin
            strb[g].en     = (cmd_op == OP_EN_ONE  && hit) || (cmd_op == OP_EN_GRP  && sel_q[g]);
            strb[g].dis    = (cmd_op == OP_DIS_ONE && hit) || (cmd_op == OP_DIS_GRP && sel_q[g]);
            strb[g].set    = (cmd_op == OP_SET_ONE && hit) || (cmd_op == OP_SET_GRP && sel_q[g]);
            strb[g].sel_wr = (cmd_op == OP_SEL_WR  && hit);
            strb[g].adr_wr = (cmd_op == OP_ADR_WR  && hit);
        end
    end
endmodule

// File: rtl/ivf_entry.sv
// Module: ivf_entry
// Holds one interrupt entry: enable, select, pending and handler address.
// A new set or event wins over a same-cycle acknowledge clear.
module ivf_entry
    import ivf_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ivf_strobe_t       strb,
    input  logic              sel_din,
    input  logic [ADDR_W-1:0] adr_din,
    input  logic              evt,
    input  logic              ack_clr,
    output logic              en_q,
    output logic              sel_q,
    output logic              pend_q,
    output logic [ADDR_W-1:0] adr_q
);
    // Enable flag: set or clear by command strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)          en_q <= 1'b0;
        else if (strb.en)    en_q <= 1'b1;
        else if (strb.dis)   en_q <= 1'b0;
    end

    // Select flag: written directly from data bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)            sel_q <= 1'b0;
        else if (strb.sel_wr)  sel_q <= sel_din;
    end

    // Pending flag: raised by event or set, lowered by acknowledge of this entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                pend_q <= 1'b0;
        else if (evt || strb.set)  pend_q <= 1'b1;
        else if (ack_clr)          pend_q <= 1'b0;
    end

    // Handler address: written whole by command.
    always_ff @(posedge clk) begin
        if (!rst_n)            adr_q <= '0;
        else if (strb.adr_wr)  adr_q <= adr_din;
    end
endmodule

// File: rtl/ivf_prio.sv
// Module: ivf_prio
// Fixed-priority arbiter with the lowest index first. It produces a one-hot
// grant and the winner's address, or zero when nothing requests. It is purely
// combinational.
module ivf_prio #(
    parameter int NUM_SRC = 4,
    parameter int ADDR_W  = 16
) (
    input  logic [NUM_SRC-1:0]             req,
    input  logic [NUM_SRC-1:0][ADDR_W-1:0] adr_tab,
    output logic                           any,
    output logic [NUM_SRC-1:0]             grant,
    output logic [ADDR_W-1:0]              vec
);
    // Scan from the top down so the lowest requesting index is written last.
    always_comb begin
        grant = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) grant = NUM_SRC'(1) << i;
        end
    end

    // Select the granted address through an AND-OR mux.
    always_comb begin
        vec = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            vec = vec | (adr_tab[i] & {ADDR_W{grant[i]}});
        end
    end

    // Flag that some entry requests.
    always_comb any = |req;
endmodule

// File: rtl/irq_vector_file.sv
// Module: irq_vector_file
// Top of the interrupt vector file: command decode, one entry per bus, and
// lowest-index arbitration. The request is gated by the global enable bit.
// Assumes cmd_idx < NUM_SRC.
module irq_vector_file
    import ivf_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int ADDR_W  = 16,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         cmd_op,
    input  logic [IDX_W-1:0]   cmd_idx,
    input  logic [ADDR_W-1:0]  cmd_data,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               gie_i,
    input  logic               ack_i,
    output logic               irq_o,
    output logic [ADDR_W-1:0]  vec_o
);
    ivf_strobe_t                    strb [NUM_SRC];
    logic [NUM_SRC-1:0]             en_q;
    logic [NUM_SRC-1:0]             sel_q;
    logic [NUM_SRC-1:0]             pend_q;
    logic [NUM_SRC-1:0][ADDR_W-1:0] adr_q;
    logic [NUM_SRC-1:0]             grant;
    logic [NUM_SRC-1:0]             ack_clr;
    logic                           any_req;

    ivf_cmd_dec #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_dec (
        .cmd_op (cmd_op),
        .cmd_idx(cmd_idx),
        .sel_q  (sel_q),
        .strb   (strb)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_ent
        ivf_entry #(.ADDR_W(ADDR_W)) u_ent (
            .clk    (clk),
            .rst_n  (rst_n),
            .strb   (strb[g]),
            .sel_din(cmd_data[0]),
            .adr_din(cmd_data),
            .evt    (evt_i[g]),
            .ack_clr(ack_clr[g]),
            .en_q   (en_q[g]),
            .sel_q  (sel_q[g]),
            .pend_q (pend_q[g]),
            .adr_q  (adr_q[g])
        );
    end

    ivf_prio #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_prio (
        .req    (pend_q & en_q),
        .adr_tab(adr_q),
        .any    (any_req),
        .grant  (grant),
        .vec    (vec_o)
    );

    // Gate the request with the global interrupt-enable bit.
    always_comb irq_o = gie_i & any_req;

    // Route an accepted acknowledge to the granted entry only.
    always_comb ack_clr = grant & {NUM_SRC{ack_i & irq_o}};
endmodule

// File: rtl/irq_vector_file_chk.sv
// Module: irq_vector_file_chk
// Property checker for irq_vector_file, attached with bind. It assumes an
// in-range cmd_idx and at most one command per cycle.
module irq_vector_file_chk #(
    parameter int NUM_SRC = 4,
    parameter int ADDR_W  = 16,
    parameter int IDX_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [3:0]         cmd_op,
    input logic [IDX_W-1:0]   cmd_idx,
    input logic [NUM_SRC-1:0] evt_i,
    input logic               gie_i,
    input logic               ack_i,
    input logic               irq_o,
    input logic [ADDR_W-1:0]  vec_o,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [NUM_SRC-1:0] grant
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (en_q == '0 && pend_q == '0));

    p_en_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 4'd1) |=> en_q[$past(cmd_idx)]);

    p_dis_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 4'd2) |=> !en_q[$past(cmd_idx)]);

    p_event_pends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

    p_gie_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_i |-> !irq_o);

    p_req_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((pend_q & en_q) != '0));

    p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_idle_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0) |-> (vec_o == '0));

    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && evt_i == '0 && cmd_op != 4'd3 && cmd_op != 4'd6)
        |=> ((pend_q & $past(grant)) == '0));
endmodule

bind irq_vector_file irq_vector_file_chk #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_op (cmd_op),
    .cmd_idx(cmd_idx),
    .evt_i  (evt_i),
    .gie_i  (gie_i),
    .ack_i  (ack_i),
    .irq_o  (irq_o),
    .vec_o  (vec_o),
    .en_q   (en_q),
    .pend_q (pend_q),
    .grant  (grant)
);

// File: tb/irq_vector_file_tb.sv
// Bench for irq_vector_file: a vector table walked by one loop, then directed
// reset checks.
module irq_vector_file_tb;
    localparam int N   = 4;
    localparam int AW  = 16;
    localparam int ROWS = 34;
    // Row layout: op[44:41] idx[40:39] data[38:23] evt[22:19] gie[18] ack[17] irq[16] vec[15:0]
    localparam logic [44:0] TBL [ROWS] = '{
        {4'd8, 2'd0, 16'h1000, 4'b0000, 1'b1, 1'b0, 1'b0, 16'h0000}, // R6 addr writes
        {4'd8, 2'd1, 16'h1100, 4'b0000, 1'b1, 1'b0, 1'b0, 16'h0000}, // R6
        {4'd8, 2'd2, 16'h1200, 4'b0000, 1'b1, 1'b0, 1'b0, 16'h0000}, // R6
        {4'd8, 2'd3, 16'h1300, 4'b0000, 1'b1, 1'b0, 1'b0, 16'h0000}, // R6
        {4'd3, 2'd2, 16'h0000, 4'b0000, 1'b1, 1'b0, 1'b0, 16'h0000}, // R3 R7 pending but disabled
        {4'd1, 2'd2, 16'h0000, 4'b0000, 1'b1, 1'b0, 1'b1, 16'h1200}, // R2 R7 held pending now requests
        {4'd1, 2'd3, 16'h0000, 4'b0000, 1'b1, 1'b0, 1'b1, 16'h1200}, // R2
        {4'd0, 2'd0, 16'h0000, 4'b1000, 1'b1, 1'b0, 1'b1, 16'h1200}, // R4 R8 entry 2 still wins
        {4'd0, 2'd0, 16'h0000, 4'b0000, 1'b1, 1'b1, 1'b1, 16'h1300}, // R9 ack clears 2
        {4'd0, 2'd0, 16'h0000, 4'b0000, 1'b1, 1'b1, 1'b0, 16'h0000}, // R9 ack clears 3
        {4'd0, 2'd0, 16'h0000, 4'b0000, 1'b1, 1'b1, 1'b0, 16'h0000}, // R9 idle ack
        {4'd0, 2'd0, 16'h0000, 4'b0001, 1'b1, 1'b0, 1'b0, 16'h0000}, // R4 entry 0 disabled
        {4'd1, 2'd0, 16'h0000, 4'b0000, 1'b1, 1'b0, 1'b1, 16'h1000}, // R2 R8
        {4'd7, 2'd1, 16'h0001, 4'b0000, 1'b1, 1'b0, 1'b1, 16'h1000}, // R6 select 1
        {4'd7, 2'd3, 16'h0001, 4'b0000, 1'b1, 1'b0, 1'b1, 16'h1000}, // R6 select 3
        {4'd6, 2'd0, 16'h0000, 4'b0000, 1'b1, 1'b0, 1'b1, 16'h1000}, // R5 group set (1,3)
        {4'd4, 2'd0, 16'h0000, 4'b0000, 1'b1, 1'b0, 1'b1, 16'h1000}, // R5 R8 group enable, 0 still lowest
        {4'd2, 2'd0, 16'h0000, 4'b0000, 1'b1, 1'b0, 1'b1, 16'h1100}, // R2 R8
        {4'd0, 2'd0, 16'h0000, 4'b0000, 1'b0, 1'b0, 1'b0, 16'h1100}, // R7 R8 gie off, vec kept
        {4'd0, 2'd0, 16'h0000, 4'b0000, 1'b0, 1'b1, 1'b0, 16'h1100}, // R9 ack ignored while irq low
        {4'd5, 2'd0, 16'h0000, 4'b0000, 1'b1, 1'b0, 1'b0, 16'h0000}, // R5 group disable
        {4'd1, 2'd2, 16'h0000, 4'b0100, 1'b1, 1'b0, 1'b1, 16'h1200}, // R2 R4
        {4'd0, 2'd0, 16'h0000, 4'b0100, 1'b1, 1'b1, 1'b1, 16'h1200}, // R10 event beats ack
        {4'd3, 2'd2, 16'h0000, 4'b0000, 1'b1, 1'b1, 1'b1, 16'h1200}, // R10 set beats ack
        {4'd9, 2'd0, 16'h5555, 4'b0000, 1'b1, 1'b0, 1'b1, 16'h1200}, // R11 unused opcode
        {4'd15,2'd2, 16'h0000, 4'b0000, 1'b1, 1'b0, 1'b1, 16'h1200}, // R11 unused opcode
        {4'd0, 2'd0, 16'h0000, 4'b0000, 1'b1, 1'b1, 1'b0, 16'h0000}, // R9 ack clears 2, rest disabled
        {4'd4, 2'd0, 16'h0000, 4'b0000, 1'b1, 1'b0, 1'b1, 16'h1100}, // R5 group enable
        {4'd7, 2'd1, 16'h0000, 4'b0000, 1'b1, 1'b0, 1'b1, 16'h1100}, // R6 deselect 1
        {4'd5, 2'd0, 16'h0000, 4'b0000, 1'b1, 1'b0, 1'b1, 16'h1100}, // R5 only 3 disabled
        {4'd0, 2'd0, 16'h0000, 4'b0000, 1'b1, 1'b1, 1'b0, 16'h0000}, // R9
        {4'd1, 2'd3, 16'h0000, 4'b0000, 1'b1, 1'b0, 1'b1, 16'h1300}, // R2 R7 pending kept while disabled
        {4'd8, 2'd3, 16'hABCD, 4'b0000, 1'b1, 1'b0, 1'b1, 16'hABCD}, // R6 addr of live winner
        {4'd0, 2'd0, 16'h0000, 4'b0000, 1'b1, 1'b0, 1'b1, 16'hABCD}  // R11
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    cmd_op = '0;
    logic [1:0]    cmd_idx = '0;
    logic [AW-1:0] cmd_data = '0;
    logic [N-1:0]  evt_i = '0;
    logic          gie_i = 1'b0;
    logic          ack_i = 1'b0;
    logic          irq_o;
    logic [AW-1:0] vec_o;
    int            n_chk = 0;
    int            n_err = 0;

    always #2.5 clk = ~clk;

    irq_vector_file #(.NUM_SRC(N), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
        .cmd_data(cmd_data), .evt_i(evt_i), .gie_i(gie_i), .ack_i(ack_i),
        .irq_o(irq_o), .vec_o(vec_o)
    );

    task automatic check(input string req, input logic e_irq, input logic [AW-1:0] e_vec);
        n_chk++;
        if (irq_o !== e_irq || vec_o !== e_vec) begin
            n_err++;
            $display("FAIL %s: irq=%b vec=%h expected irq=%b vec=%h", req, irq_o, vec_o, e_irq, e_vec);
        end
    endtask

    task automatic step(input logic [3:0] op, input logic [1:0] idx, input logic [AW-1:0] d,
                        input logic [N-1:0] ev, input logic g, input logic a);
        cmd_op = op; cmd_idx = idx; cmd_data = d; evt_i = ev; gie_i = g; ack_i = a;
        @(posedge clk);
        @(negedge clk);
        cmd_op = '0; evt_i = '0; ack_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        gie_i = 1'b1;
        check("R1 after reset", 1'b0, 16'h0000);
        rst_n = 1'b1;
        for (int r = 0; r < ROWS; r++) begin
            step(TBL[r][44:41], TBL[r][40:39], TBL[r][38:23], TBL[r][22:19], TBL[r][18], TBL[r][17]);
            check($sformatf("table row %0d (tags in table)", r), TBL[r][16], TBL[r][15:0]);
        end
        // R1: a mid-run reset clears flags and addresses.
        rst_n = 1'b0;
        step(4'd0, 2'd0, 16'h0, 4'b0000, 1'b1, 1'b0);
        rst_n = 1'b1;
        check("R1 reset clears live request", 1'b0, 16'h0000);
        step(4'd6, 2'd0, 16'h0, 4'b0000, 1'b1, 1'b0);   // selects cleared: group set hits nothing
        step(4'd1, 2'd3, 16'h0, 4'b0000, 1'b1, 1'b0);
        check("R1 select and pending cleared", 1'b0, 16'h0000);
        step(4'd3, 2'd3, 16'h0, 4'b0000, 1'b1, 1'b0);
        check("R1 address reset to zero", 1'b1, 16'h0000);
        step(4'd3, 2'd0, 16'h0, 4'b0000, 1'b1, 1'b0);   // entry 0 enable was cleared by reset
        step(4'd2, 2'd3, 16'h0, 4'b0000, 1'b1, 1'b0);
        check("R1 enable cleared", 1'b0, 16'h0000);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule